// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous SRAM organised as 32-bit words split into four byte lanes. An access begins when the address strobe captures an external address. Later cycles with the advance input asserted then walk through the other three words of the same four-word group. The walk follows either a wrapping +1 count or an XOR-interleaved count, chosen by a mode input. The upper address bits stay fixed for the whole burst. The counter holds two bits, so the fifth beat of a burst returns to the word where the burst started.

Each cycle is either a write or a read. A global write stores all four bytes. A byte write stores only the lanes whose select lines are low. A second mode input picks the read path. In flow-through mode the data is valid one clock after the access. In pipelined mode an extra output register adds one more clock. A sleep input puts the block in standby, where no access takes place.

The output bus is never tristated. A valid flag instead marks the cycles in which the output carries read data. The depth is a parameter. The full-size part uses `ADDR_W` = 16, and the default is kept small.

Top module: `burst_sram`

## Requirements
- R1: With `burstIlv` low, a burst that starts at low address bits s reaches words s, s+1, s+2 and s+3, taken modulo 4, on its first to fourth beats. The upper address bits do not change.
- R2: With `burstIlv` high, the fourth-beat sequence is s, s^1, s^2, s^3, where ^ is a bitwise XOR on the two low address bits.
- R3: On the fifth beat of a burst (the fourth advance after the load), the access returns to the starting word.
- R4: With `gwN` low, all four bytes of the accessed word are written from `din`, whatever `bweN` and `bselN` are.
- R5: With `gwN` high and `bweN` low, exactly those lanes i with `bselN[i]` low are written. Lane i is `din[8i+7:8i]`. The other lanes keep their contents.
- R6: With `gwN` high, the cycle is a read if `bweN` is high or all four `bselN` bits are high. Such a cycle changes no memory content.
- R7: With `pipeMode` low (flow-through), read data and a high `doutValid` appear in the cycle after the read is clocked.
- R8: With `pipeMode` high (pipelined), read data and a high `doutValid` appear two cycles after the read is clocked. One cycle after, `doutValid` is low.
- R9: `doutValid` is low in the output slot that belongs to a write cycle or to a deselected cycle (`ceN` high).
- R10: While `sleep` is high, no read or write happens, the burst state holds, and `doutValid` is low.
- R11: A low `adsN` loads the address even when `advN` is also low. In that cycle the word at the loaded address is the one accessed.
- R12: After reset, `doutValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of control and valid state |
| addr | input | ADDR_W | External word address |
| ceN | input | 1 | Active-low chip enable |
| adsN | input | 1 | Active-low address strobe; loads the burst counter |
| advN | input | 1 | Active-low burst advance |
| gwN | input | 1 | Active-low global write (all bytes) |
| bweN | input | 1 | Active-low byte-write enable |
| bselN | input | 4 | Active-low per-lane byte selects |
| burstIlv | input | 1 | Burst order: 1 interleaved, 0 linear |
| pipeMode | input | 1 | Read path: 1 pipelined, 0 flow-through |
| sleep | input | 1 | 1 forces standby |
| din | input | 32 | Write data |
| dout | output | 32 | Read data |
| doutValid | output | 1 | High when `dout` carries read data |

## Verification
A wrong burst counter or start register stores a burst's beats at the wrong words. This shows on the ports once those words are read back one by one through the address strobe, which happens a few cycles after the burst ends. A wrong lane decode is seen on the next read of the same word, as a byte that changed or failed to change. Errors in the read-path registers show in the first read slot after the access, as a shifted `doutValid` pulse or as stale data.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [LANES-1:0] laneWe;
    logic             sleep;
  } ctlStrobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              adsN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bselN,
  input  logic              burstIlv,
  input  logic              sleep,
  output ctlStrobe_t        ctl,
  output logic [ADDR_W-1:0] accAddr
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hiReg;
  logic [1:0]      startLow;
  logic [1:0]      count;
  logic [1:0]      lastLow;
  logic            active, load, step;
  logic [1:0]      nextCount, baseLow, offLow;
  logic [LANES-1:0] laneSel;

  assign active = !ceN && !sleep;
  assign load   = active && !adsN;
  assign step   = active && adsN && !advN;

  always_comb begin
    nextCount = count;
    if (load)      nextCount = 2'd0;
    else if (step) nextCount = count + 2'd1;
    baseLow = load ? addr[1:0] : startLow;
    offLow  = burstIlv ? (baseLow ^ nextCount) : (baseLow + nextCount);
    accAddr = load ? addr : {hiReg, offLow};
  end

  always_comb begin
    if (!gwN)       laneSel = '1;
    else if (!bweN) laneSel = ~bselN;
    else            laneSel = '0;
    ctl.laneWe = active ? laneSel : '0;
    ctl.wrEn   = active && (|laneSel);
    ctl.rdEn   = active && !(|laneSel);
    ctl.sleep  = sleep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg    <= '0;
      startLow <= '0;
      count    <= '0;
      lastLow  <= '0;
    end else begin
      if (load) begin
        hiReg    <= addr[ADDR_W-1:2];
        startLow <= addr[1:0];
      end
      count <= nextCount;
      if (active) lastLow <= accAddr[1:0];
    end
  end

  // R3
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && count == 2'd3) |=> (lastLow == startLow));

  // R11
  strobe_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (startLow == $past(addr[1:0]) && lastLow == $past(addr[1:0])));

  // R10
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(count) && $stable(startLow)));
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] din,
  input  logic              pipeMode,
  output logic [DATA_W-1:0] dout,
  output logic              doutValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] rd1;
  logic [DATA_W-1:0]            rd2;
  logic                         v1, v2;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] q1;
    always_ff @(posedge clk) begin
      if (ctl.laneWe[l]) laneMem[accAddr] <= din[l*LANE_W +: LANE_W];
      if (ctl.rdEn)      q1 <= laneMem[accAddr];
    end
    assign rd1[l] = q1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= ctl.rdEn;
      v2 <= ctl.sleep ? 1'b0 : v1;
    end
  end

  always_ff @(posedge clk) rd2 <= rd1;

  assign dout      = pipeMode ? rd2 : rd1;
  assign doutValid = (pipeMode ? v2 : v1) && !ctl.sleep;

  // R9
  write_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> !v1);

  // R10
  sleep_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sleep |=> (!v1 && !v2));

  // R8
  pipe_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    (v1 && !ctl.sleep) |=> v2);

  // R6
  one_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wrEn && ctl.rdEn));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              adsN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [3:0]        bselN,
  input  logic              burstIlv,
  input  logic              pipeMode,
  input  logic              sleep,
  input  logic [31:0]       din,
  output logic [31:0]       dout,
  output logic              doutValid
);
  ctlStrobe_t        ctl;
  logic [ADDR_W-1:0] accAddr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .adsN(adsN),
    .advN(advN), .gwN(gwN), .bweN(bweN), .bselN(bselN),
    .burstIlv(burstIlv), .sleep(sleep), .ctl(ctl), .accAddr(accAddr)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accAddr(accAddr), .din(din),
    .pipeMode(pipeMode), .dout(dout), .doutValid(doutValid)
  );
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN;
  logic [AW-1:0] addr;
  logic ceN, adsN, advN, gwN, bweN, burstIlv, pipeMode, sleep;
  logic [3:0] bselN;
  logic [31:0] din, dout;
  logic doutValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .adsN(adsN), .advN(advN),
    .gwN(gwN), .bweN(bweN), .bselN(bselN), .burstIlv(burstIlv),
    .pipeMode(pipeMode), .sleep(sleep), .din(din), .dout(dout),
    .doutValid(doutValid)
  );

  // {interleaved, start low bits, expected low bits on beats 1..4}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'b00, 8'b00_01_10_11},
    {1'b0, 2'b01, 8'b01_10_11_00},
    {1'b0, 2'b10, 8'b10_11_00_01},
    {1'b0, 2'b11, 8'b11_00_01_10},
    {1'b1, 2'b00, 8'b00_01_10_11},
    {1'b1, 2'b01, 8'b01_00_11_10},
    {1'b1, 2'b10, 8'b10_11_00_01},
    {1'b1, 2'b11, 8'b11_10_01_00}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic c, logic a, logic v, logic g, logic b,
                       logic [3:0] s, logic [AW-1:0] ad, logic [31:0] d);
    ceN = c; adsN = a; advN = v; gwN = g; bweN = b; bselN = s; addr = ad; din = d;
    tick();
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
  endtask

  task automatic readFlow(logic [AW-1:0] ad, output logic [31:0] d, output logic v);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, ad, '0);
    d = dout;
    v = doutValid;
  endtask

  logic [31:0] rd;
  logic rv;

  initial begin
    rstN = 1'b0; burstIlv = 1'b0; pipeMode = 1'b0; sleep = 1'b0;
    ceN = 1'b1; adsN = 1'b1; advN = 1'b1; gwN = 1'b1; bweN = 1'b1;
    bselN = 4'hF; addr = '0; din = '0;
    tick(); tick();
    check("R12 reset valid", {31'd0, doutValid}, 32'd0);
    rstN = 1'b1;
    idle();

    // Burst order table: write 4 beats, read each expected word back (R1, R2, R7)
    for (int r = 0; r < 8; r++) begin
      logic [5:0] hi;
      hi = 6'(r + 1);
      burstIlv = VEC[r][10];
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, {hi, VEC[r][9:8]}, 32'hC0DE_0000 | (r << 8));
      for (int b = 1; b < 4; b++)
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, '0, 32'hC0DE_0000 | (r << 8) | b);
      idle();
      for (int b = 0; b < 4; b++) begin
        logic [1:0] lo;
        lo = VEC[r][7 - 2*b -: 2];
        readFlow({hi, lo}, rd, rv);
        check(VEC[r][10] ? "R2 interleaved order" : "R1 linear order",
              rd, 32'hC0DE_0000 | (r << 8) | b);
        check("R7 flow valid", {31'd0, rv}, 32'd1);
      end
      idle();
    end
    burstIlv = 1'b0;

    // R3: fifth beat returns to start
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, {6'd20, 2'b01}, 32'h5000_0000);
    check("R9 write slot", {31'd0, doutValid}, 32'd0);
    for (int b = 1; b < 5; b++)
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, '0, 32'h5000_0000 | b);
    idle();
    check("R9 deselect slot", {31'd0, doutValid}, 32'd0);
    readFlow({6'd20, 2'b01}, rd, rv);
    check("R3 wrap overwrote start", rd, 32'h5000_0004);
    readFlow({6'd20, 2'b10}, rd, rv);
    check("R3 second word intact", rd, 32'h5000_0001);

    // R11: strobe wins over advance
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, {6'd21, 2'b10}, 32'h1111_2222);
    readFlow({6'd21, 2'b10}, rd, rv);
    check("R11 load with advance", rd, 32'h1111_2222);
    readFlow({6'd21, 2'b11}, rd, rv);
    check("R11 next word untouched", rd === 32'h1111_2222 ? 32'd1 : 32'd0, 32'd0);

    // R4 / R5 / R6 lane decode
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, {6'd30, 2'b00}, 32'h1111_1111);
    readFlow({6'd30, 2'b00}, rd, rv);
    check("R4 global write ignores selects", rd, 32'h1111_1111);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010, {6'd30, 2'b00}, 32'hAABB_CCDD);
    readFlow({6'd30, 2'b00}, rd, rv);
    check("R5 lanes 0 and 2", rd, 32'h11BB_11DD);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, {6'd30, 2'b00}, 32'h0);
    check("R6 bwe high is read", {31'd0, doutValid}, 32'd1);
    check("R6 bwe high data", dout, 32'h11BB_11DD);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, {6'd30, 2'b00}, 32'h0);
    check("R6 no selects is read", {31'd0, doutValid}, 32'd1);
    readFlow({6'd30, 2'b00}, rd, rv);
    check("R6 memory unchanged", rd, 32'h11BB_11DD);

    // R8 pipelined latency
    pipeMode = 1'b1;
    idle();
    readFlow({6'd30, 2'b00}, rd, rv);
    check("R8 not yet valid", {31'd0, rv}, 32'd0);
    idle();
    check("R8 valid after two", {31'd0, doutValid}, 32'd1);
    check("R8 pipelined data", dout, 32'h11BB_11DD);
    idle();
    pipeMode = 1'b0;

    // R10 sleep blocks access
    sleep = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, {6'd30, 2'b00}, 32'hDEAD_BEEF);
    check("R10 sleep valid low", {31'd0, doutValid}, 32'd0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, {6'd30, 2'b00}, 32'h0);
    check("R10 sleep read blocked", {31'd0, doutValid}, 32'd0);
    sleep = 1'b0;
    readFlow({6'd30, 2'b00}, rd, rv);
    check("R10 write blocked", rd, 32'h11BB_11DD);

    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule